// File: doc/BRIEF.md
# Read-Preamble Capture Delay Trainer

This block calibrates the receive capture point of a double-data-rate flash read. Near the end of the dummy phase of each read, the memory drives a known 8-bit training word on every active data line, one bit per clock edge, most significant bit first. A delay line outside this block presents, for each candidate capture delay (tap), the value that every data line gives when sampled at that delay. For each tap, the trainer compares those values against the programmed word, one beat at a time.

After the eighth beat, the trainer has a mask of passing taps. It finds the longest contiguous run of passing taps and selects its midpoint. The selected tap is then used for the data phase of the same read. Training is repeated on every read, so drift in process, voltage, temperature and board flight time is tracked from one read to the next. If no tap passes, a fail flag is raised and the previously selected tap is kept.

The training word and the bus width (x1, x2 or x4) are captured when a read starts. The host may therefore reprogram them freely between reads.

Top module: `dlp_trainer`

## Requirements
- R1: After reset, `sel_tap` is 0 and both `lock` and `fail` are low.
- R2: A tap passes only if, on all eight beats of the window, every active line at that tap equals the corresponding training bit. Beat 0 carries bit 7 of the word and beat 7 carries bit 0. Tap t, lane l is bit `t*NLANES+l` of `tap_bits`.
- R3: Lane activity follows `lane_mode`: 2'b00 = x1 (lane 0 only), 2'b01 = x2 (lanes 0 and 1), 2'b10 or 2'b11 = x4 (lanes 0 to 3). The values on inactive lanes have no effect on the result.
- R4: When at least one tap passes, `sel_tap` equals start + (length-1)/2, rounded down, for the longest run of adjacent passing taps. When two runs are equally long, the run at the lowest tap wins. `lock` rises and `fail` stays low.
- R5: When no tap passes, `fail` rises, `lock` stays low, and `sel_tap` keeps its previous value.
- R6: `pat_cfg` and `lane_mode` are sampled only in the cycle where `rd_start` is high. Changes to them later in the same read have no effect.
- R7: `rd_start` clears `lock` and `fail` at the next edge. The result becomes visible one cycle after the clock edge that takes the eighth beat, and not before.
- R8: Cycles in which `train_win` stays high after the eighth beat, up to the next `rd_start`, have no effect on the result.
- R9: A `rd_start` during an unfinished window abandons that window. The new read is then trained from a clean pass mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start | input | 1 | Pulse at the start of a read; captures the word and the mode |
| pat_cfg | input | 8 | Programmed training word |
| lane_mode | input | 2 | Bus width: 00 x1, 01 x2, 1x x4 |
| train_win | input | 1 | High for each beat of the training window |
| tap_bits | input | NTAPS*NLANES | Sampled line value per tap and lane |
| sel_tap | output | $clog2(NTAPS) | Selected capture tap |
| lock | output | 1 | Last training found a passing tap |
| fail | output | 1 | Last training found no passing tap |

## Verification
The bench uses the default 8 taps and 4 lanes. With that size it can apply every one of the 256 pass masks in x4 mode, so every run layout, tie between runs and empty mask is covered exhaustively. Each failing tap is made to fail by a single flipped bit, on a lane and beat that vary from tap to tap. This proves that one wrong beat on one lane is enough to reject a tap. Further sweeps repeat the mask space in x1 and x2 modes with inverted data on the idle lanes. They also cover scrambling the word and mode after the read starts, an overlong window, and a read restarted mid-window.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

  localparam int WORD_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRAIN = 2'd1,
    ST_EVAL  = 2'd2
  } trn_state_t;

  // number of active data lines for a bus-width code
  function automatic int unsigned lanes_for_mode(input logic [1:0] mode);
    case (mode)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return 4;
    endcase
  endfunction

  // training bit expected on a beat, most significant bit first
  function automatic logic word_bit(input logic [7:0] word, input logic [2:0] beat);
    return word[3'd7 - beat];
  endfunction

endpackage

// File: rtl/dlp_tap_cmp.sv
module dlp_tap_cmp #(
  parameter int NTAPS  = 8,
  parameter int NLANES = 4
) (
  input  logic [NTAPS*NLANES-1:0] tap_bits,
  input  logic                    exp_bit,
  input  logic [NLANES-1:0]       lane_en,
  output logic [NTAPS-1:0]        tap_ok
);
  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    logic [NLANES-1:0] miss;
    assign miss      = (tap_bits[t*NLANES +: NLANES] ^ {NLANES{exp_bit}}) & lane_en;
    assign tap_ok[t] = ~|miss;
  end
endmodule

// File: rtl/dlp_pass_acc.sv
module dlp_pass_acc #(
  parameter int NTAPS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             beat,
  input  logic [NTAPS-1:0] tap_ok,
  output logic [NTAPS-1:0] pass_mask,
  output logic [3:0]       beat_cnt,
  output logic             last_beat
);
  assign last_beat = beat && (beat_cnt == 4'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_mask <= '0;
      beat_cnt  <= '0;
    end else if (clr) begin
      pass_mask <= '1;
      beat_cnt  <= '0;
    end else if (beat) begin
      pass_mask <= pass_mask & tap_ok;
      beat_cnt  <= beat_cnt + 4'd1;
    end
  end

  // R2: a beat can only remove taps from the passing set, never add one
  a_r2_mask_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !clr) |=> ((pass_mask & ~$past(pass_mask)) == '0));

  // R8: never more than eight beats are counted per window
  a_r8_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt <= 4'd8);
endmodule

// File: rtl/dlp_window_pick.sv
module dlp_window_pick #(
  parameter int NTAPS = 8,
  localparam int TAPW = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
  input  logic [NTAPS-1:0] pass_mask,
  output logic             found,
  output logic [TAPW-1:0]  mid_tap
);
  always_comb begin
    int run;
    int run_st;
    int best_len;
    int best_st;
    run      = 0;
    run_st   = 0;
    best_len = 0;
    best_st  = 0;
    for (int t = 0; t < NTAPS; t++) begin
      if (pass_mask[t]) begin
        if (run == 0) run_st = t;
        run = run + 1;
        if (run > best_len) begin
          best_len = run;
          best_st  = run_st;
        end
      end else begin
        run = 0;
      end
    end
    found   = (best_len != 0);
    mid_tap = found ? TAPW'(best_st + (best_len - 1) / 2) : '0;
  end
endmodule

// File: rtl/dlp_trainer.sv
module dlp_trainer #(
  parameter int NTAPS  = 8,
  parameter int NLANES = 4,
  localparam int TAPW  = (NTAPS > 1) ? $clog2(NTAPS) : 1,
  localparam int NBITS = NTAPS * NLANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_start,
  input  logic [7:0]       pat_cfg,
  input  logic [1:0]       lane_mode,
  input  logic             train_win,
  input  logic [NBITS-1:0] tap_bits,
  output logic [TAPW-1:0]  sel_tap,
  output logic             lock,
  output logic             fail
);
  import dlp_pkg::*;

  trn_state_t        state;
  logic [7:0]        pat_q;
  logic [NLANES-1:0] lane_en_q;
  logic [NLANES-1:0] lane_en_d;

  // named internal events
  logic              beat;
  logic              exp_bit;
  logic [NTAPS-1:0]  tap_ok;
  logic [NTAPS-1:0]  pass_mask;
  logic [3:0]        beat_cnt;
  logic              last_beat;
  logic              found;
  logic [TAPW-1:0]   mid_tap;
  logic              eval_now;

  always_comb begin
    for (int l = 0; l < NLANES; l++)
      lane_en_d[l] = lanes_for_mode(lane_mode) > unsigned'(l);
  end

  assign beat     = (state == ST_TRAIN) && train_win && !rd_start;
  assign exp_bit  = word_bit(pat_q, beat_cnt[2:0]);
  assign eval_now = (state == ST_EVAL) && !rd_start;

  dlp_tap_cmp #(.NTAPS(NTAPS), .NLANES(NLANES)) u_cmp (
    .tap_bits (tap_bits),
    .exp_bit  (exp_bit),
    .lane_en  (lane_en_q),
    .tap_ok   (tap_ok)
  );

  dlp_pass_acc #(.NTAPS(NTAPS)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rd_start),
    .beat      (beat),
    .tap_ok    (tap_ok),
    .pass_mask (pass_mask),
    .beat_cnt  (beat_cnt),
    .last_beat (last_beat)
  );

  dlp_window_pick #(.NTAPS(NTAPS)) u_pick (
    .pass_mask (pass_mask),
    .found     (found),
    .mid_tap   (mid_tap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pat_q     <= '0;
      lane_en_q <= '0;
      sel_tap   <= '0;
      lock      <= 1'b0;
      fail      <= 1'b0;
    end else if (rd_start) begin
      state     <= ST_TRAIN;
      pat_q     <= pat_cfg;
      lane_en_q <= lane_en_d;
      lock      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      case (state)
        ST_TRAIN: if (last_beat) state <= ST_EVAL;
        ST_EVAL: begin
          state <= ST_IDLE;
          if (found) begin
            sel_tap <= mid_tap;
            lock    <= 1'b1;
          end else begin
            fail    <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: lock and fail are never both high
  a_r7_lock_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock && fail));

  // R7: a read start clears the previous verdict
  a_r7_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (!lock && !fail));

  // R4: a locked tap lies inside the passing set
  a_r4_tap_passes: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> pass_mask[sel_tap]);

  // R5: an empty passing set keeps the old tap and flags failure
  a_r5_keep_tap: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_now && !found) |=> (fail && !lock && $stable(sel_tap)));

  // R6: the training word is held for the whole read
  a_r6_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !rd_start) |=> $stable(pat_q));
endmodule

// File: tb/sim_dlp_trainer.sv
`timescale 1ns/1ps
module sim_dlp_trainer;
  localparam int NT = 8;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_start = 1'b0;
  logic [7:0]    pat_cfg = 8'h00;
  logic [1:0]    lane_mode = 2'b10;
  logic          train_win = 1'b0;
  logic [NT*NL-1:0] tap_bits = '0;
  logic [2:0]    sel_tap;
  logic          lock, fail;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int exp_tap = 0;

  always #2 clk = ~clk;

  dlp_trainer #(.NTAPS(NT), .NLANES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .pat_cfg(pat_cfg),
    .lane_mode(lane_mode), .train_win(train_win), .tap_bits(tap_bits),
    .sel_tap(sel_tap), .lock(lock), .fail(fail)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired: actual cycle %0d expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // longest run measured by its end point; midpoint = end - len/2
  task automatic model(input logic [7:0] m, output bit ok, output int tap);
    int best_len = 0;
    int best_end = 0;
    for (int e = 0; e < NT; e++) begin
      int len = 0;
      for (int k = e; k >= 0 && m[k]; k--) len++;
      if (len > best_len) begin best_len = len; best_end = e; end
    end
    ok  = best_len > 0;
    tap = best_end - best_len / 2;
  endtask

  function automatic int mode_lanes(input logic [1:0] md);
    return (md == 2'b00) ? 1 : (md == 2'b01) ? 2 : 4;
  endfunction

  task automatic drive_beat(input logic [7:0] pat, input logic [1:0] md,
                            input logic [7:0] m, input int seed, input int b);
    int cnt = mode_lanes(md);
    logic bv;
    bv = pat[7-b];
    for (int t = 0; t < NT; t++)
      for (int l = 0; l < NL; l++) begin
        logic v;
        v = bv;
        if (l >= cnt) v = ~bv;
        else if (!m[t] && l == (t + seed) % cnt && b == (t * 3 + seed) % 8) v = ~bv;
        tap_bits[t*NL+l] = v;
      end
    train_win = 1'b1;
  endtask

  task automatic start_read(input logic [7:0] pat, input logic [1:0] md);
    @(negedge clk);
    rd_start = 1'b1; pat_cfg = pat; lane_mode = md; train_win = 1'b0;
    @(negedge clk);
    rd_start = 1'b0;
    chk("R7 clear lock", int'(lock), 0);
    // R6: scramble the word and mode after the start
    pat_cfg = ~pat; lane_mode = (md == 2'b00) ? 2'b10 : 2'b00;
  endtask

  task automatic do_read(input logic [7:0] pat, input logic [1:0] md,
                         input logic [7:0] m, input int seed, input bit extra,
                         input string req);
    bit ok; int tap;
    start_read(pat, md);
    for (int b = 0; b < 8; b++) begin
      drive_beat(pat, md, m, seed, b);
      @(negedge clk);
    end
    if (extra) tap_bits = '0; else train_win = 1'b0;
    chk("R7 not early", int'(lock | fail), 0);
    @(negedge clk);
    model(m, ok, tap);
    if (ok) exp_tap = tap;
    chk({req, " lock"}, int'(lock), int'(ok));
    chk({req, " fail"}, int'(fail), int'(!ok));
    chk({req, " tap"}, int'(sel_tap), exp_tap);
    if (extra) begin
      @(negedge clk); @(negedge clk);
      train_win = 1'b0;
      chk("R8 extra beats tap", int'(sel_tap), exp_tap);
      chk("R8 extra beats lock", int'(lock), int'(ok));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset tap", int'(sel_tap), 0);
    chk("R1 reset lock", int'(lock), 0);
    chk("R1 reset fail", int'(fail), 0);
    rst_n = 1'b1;

    // R2 R4 R5: every pass mask in x4 with the usual word
    for (int m = 0; m < 256; m++) do_read(8'h34, 2'b10, 8'(m), m, 1'b0, "R2/R4/R5 x4");
    // R3: x1 and x2 with inverted data on idle lanes
    for (int m = 0; m < 256; m += 3) do_read(8'hA5, 2'b00, 8'(m), m + 1, 1'b0, "R3 x1");
    for (int m = 0; m < 256; m += 5) do_read(8'h5A, 2'b01, 8'(m), m + 2, 1'b0, "R3 x2");
    for (int m = 0; m < 256; m += 7) do_read(8'hC3, 2'b11, 8'(m), m + 3, 1'b0, "R3 x4 code 11");
    // R8: window held high past eight beats with wrong data
    do_read(8'h34, 2'b10, 8'b0011_1100, 4, 1'b1, "R8");
    do_read(8'hF0, 2'b01, 8'b1110_0011, 9, 1'b1, "R8");
    // R5: empty mask keeps tap from previous lock
    do_read(8'h34, 2'b10, 8'b0110_0000, 1, 1'b0, "R5 setup");
    do_read(8'h34, 2'b10, 8'h00, 2, 1'b0, "R5 keep");

    // R9: restart mid-window with all taps failing, then a clean read
    start_read(8'h34, 2'b10);
    for (int b = 0; b < 4; b++) begin
      drive_beat(8'h34, 2'b10, 8'h00, 0, b);
      tap_bits = '0;
      @(negedge clk);
    end
    train_win = 1'b0;
    do_read(8'h34, 2'b10, 8'b0000_1110, 5, 1'b0, "R9 restart");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule